// File: doc/BRIEF.md
# Compare-Match Refresh Interval Timer

This block paces memory refresh. It has an 8-bit up-counter, an 8-bit constant register and a 16-bit control/status word, all reached over a simple register bus with one address, one write strobe and one read strobe. A free-running prescaler divides the system clock. A 3-bit clock-select field picks one of seven divided rates, and the counter advances once per period of that rate. When the counter equals the constant, a sticky match flag is set. An interrupt request is raised while the flag and its enable bit are both set.

The flag is guarded against accidental clearing. Software must first read the control/status word while the flag shows 1, and then write 0 to the flag bit. After a match, the counter returns to zero on its next count step, so matches recur at a fixed interval of (constant + 1) × divide ratio clock cycles.

Top module: `refresh_timer`

## Requirements
- R1: After reset, the control/status word, the counter and the constant all read 0, and irq_o is low.
- R2: In the control/status word (address 0), bits 15:8 and 2:0 always read 0, and writes to them have no effect.
- R3: Address 1 is the counter and address 2 is the constant. Each is 8 bits, written from wdata_i[7:0], read back on rdata_o[7:0] with bits 15:8 read as 0.
- R4: Clock-select field bits 5:3 codes 1 to 7 select divide ratios of 2, 8, 32, 128, 512, 2048 and 4096. In any window of K×ratio consecutive cycles, the counter advances exactly K times.
- R5: Clock-select code 0 stops the counter, so its value holds.
- R6: A count step taken while the counter equals the constant loads 0 instead of incrementing, so counter values never pass the constant when counting starts below it.
- R7: The match flag (bit 7) is 1 in the cycle after the counter equals the constant while the clock-select code is non-zero. Writing 1 to bit 7 never sets it.
- R8: The flag clears only on a write of 0 to bit 7 that follows a read of address 0 which returned the flag as 1. A write of 0 without such a read leaves the flag at 1. Any write to address 0 ends the armed state.
- R9: If a match is present in the same cycle as a valid clearing write, the flag stays 1.
- R10: irq_o is high exactly while the flag and the interrupt enable (bit 6) are both 1.
- R11: A counter write in the same cycle as a count step loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address: 0 control/status, 1 counter, 2 constant |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe; a read of address 0 can arm flag clearing |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Compare-match interrupt request |

## Verification
The assertions check on every cycle that:
- reserved bits read as zero;
- the counter holds when stopped, and otherwise only holds, increments or returns to zero;
- a bus write to the counter takes effect;
- equality with a clock selected sets the flag;
- every fall of the flag is preceded by an armed clearing write.

Only the bench scenarios can show the following:
- the exact divide ratio of each select code, measured as a count delta over a window;
- the wrap period;
- that a clearing write without a prior read, or a write of 1, leaves the flag unchanged;
- that set beats clear during a held match;
- the interrupt following its enable.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int SEL_W  = 3;
  localparam int NUM_SEL = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] A_CSR = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT = 2'd1;
  localparam logic [ADDR_W-1:0] A_COR = 2'd2;

  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_SEL  = 3;

  // log2 of divide ratio for select code (1..7): 2,8,32,128,512,2048,4096
  function automatic int div_log2(int code);
    return (code == NUM_SEL - 1) ? 2 * code - 2 : 2 * code - 1;
  endfunction

  localparam int PRE_W = div_log2(NUM_SEL - 1);
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler
  import rt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0]   pre_q;
  logic [NUM_SEL-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  assign tap[0] = 1'b0;
  for (genvar k = 1; k < NUM_SEL; k++) begin : g_tap
    localparam int L = div_log2(k);
    assign tap[k] = &pre_q[L-1:0];
  end

  assign tick_o = tap[sel_i];
endmodule

// File: rtl/rt_counter.sv
module rt_counter
  import rt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_cnt_i,
  input  logic             wr_cor_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cor_o,
  output logic             eq_o
);
  logic [CNT_W-1:0] cnt_q, cor_q;

  assign eq_o = (cnt_q == cor_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_cnt_i) cnt_q <= wdata_i;
    else if (tick_i)   cnt_q <= eq_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cor_q <= '0;
    else if (wr_cor_i) cor_q <= wdata_i;
  end

  assign cnt_o = cnt_q;
  assign cor_o = cor_q;
endmodule

// File: rtl/rt_csr.sv
module rt_csr
  import rt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              eq_i,
  output logic              flag_o,
  output logic              ie_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              armed_o
);
  logic             flag_q, ie_q, armed_q;
  logic [SEL_W-1:0] sel_q;
  logic             set_flag, clr_flag;

  assign set_flag = eq_i && (sel_q != '0);
  assign clr_flag = wr_i && !wdata_i[B_FLAG] && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      sel_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (set_flag)      flag_q <= 1'b1;   // set wins over clear
      else if (clr_flag) flag_q <= 1'b0;
      if (wr_i) begin
        ie_q    <= wdata_i[B_IE];
        sel_q   <= wdata_i[B_SEL +: SEL_W];
        armed_q <= 1'b0;
      end else if (rd_i) begin
        armed_q <= flag_q;
      end
    end
  end

  assign flag_o  = flag_q;
  assign ie_o    = ie_q;
  assign sel_o   = sel_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             tick;
  logic             eq;
  logic [CNT_W-1:0] cnt_q, cor_q;
  logic             flag_q, ie_q, armed_q;
  logic [SEL_W-1:0] sel_q;
  logic             wr_csr, rd_csr, wr_cnt, wr_cor;

  assign wr_csr = wr_i && (addr_i == A_CSR);
  assign rd_csr = rd_i && !wr_i && (addr_i == A_CSR);
  assign wr_cnt = wr_i && (addr_i == A_CNT);
  assign wr_cor = wr_i && (addr_i == A_COR);

  rt_prescaler u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel_q),
    .tick_o(tick)
  );

  rt_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .wr_cnt_i(wr_cnt),
    .wr_cor_i(wr_cor),
    .wdata_i (wdata_i[CNT_W-1:0]),
    .cnt_o   (cnt_q),
    .cor_o   (cor_q),
    .eq_o    (eq)
  );

  rt_csr u_csr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_csr),
    .rd_i   (rd_csr),
    .wdata_i(wdata_i),
    .eq_i   (eq),
    .flag_o (flag_q),
    .ie_o   (ie_q),
    .sel_o  (sel_q),
    .armed_o(armed_q)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CSR: begin
        rdata_o[B_FLAG]           = flag_q;
        rdata_o[B_IE]             = ie_q;
        rdata_o[B_SEL +: SEL_W]   = sel_q;
      end
      A_CNT:   rdata_o[CNT_W-1:0] = cnt_q;
      A_COR:   rdata_o[CNT_W-1:0] = cor_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q && ie_q;
endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import rt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cor_q,
  input logic              flag_q,
  input logic              ie_q,
  input logic [SEL_W-1:0]  sel_q,
  input logic              armed_q
);
  logic wr_cnt;
  assign wr_cnt = wr_i && (addr_i == A_CNT);

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_CSR) |-> (rdata_o[15:8] == 8'd0 && rdata_o[2:0] == 3'd0));

  a_r5_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == '0 && !wr_cnt) |=> (cnt_q == $past(cnt_q)));

  a_r6_step_or_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == '0));

  a_r7_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != '0 && cnt_q == cor_q) |=> flag_q);

  a_r8_clear_by_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(armed_q && wr_i && addr_i == A_CSR && !wdata_i[B_FLAG]));

  a_r10_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (flag_q && ie_q));

  a_r11_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> (cnt_q == $past(wdata_i[CNT_W-1:0])));
endmodule

bind refresh_timer rt_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .cnt_q  (cnt_q),
  .cor_q  (cor_q),
  .flag_q (flag_q),
  .ie_q   (ie_q),
  .sel_q  (sel_q),
  .armed_q(armed_q)
);

// File: tb/refresh_timer_test.sv
module refresh_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [15:0] exp;
    bit          cmp;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  logic [15:0] cap;
  bit          done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  refresh_timer uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for every read cycle
  initial begin
    forever begin
      @(negedge clk_i);
      #5;
      if (rd_i) begin
        if (exp_q.size() == 0) begin
          check("queue", 16'hdead, 16'h0000);
        end else begin
          item_t it = exp_q.pop_front();
          if (it.cmp) check(it.tag, rdata_o, it.exp);
          else        cap = rdata_o;
        end
      end
    end
  end

  // tasks start at a falling edge and end at the next one
  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.cmp = 1'b1; it.tag = tag;
    exp_q.push_back(it);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic bus_cap(input logic [1:0] a, output logic [15:0] v);
    item_t it;
    it.exp = '0; it.cmp = 1'b0; it.tag = "cap";
    exp_q.push_back(it);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    v = cap;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #5;
    check(tag, {15'd0, irq_o}, {15'd0, exp});
    @(negedge clk_i);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    int ratio [1:7] = '{2, 8, 32, 128, 512, 2048, 4096};
    idle(2);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    bus_rd(2'd0, 16'h0000, "R1 csr");
    bus_rd(2'd1, 16'h0000, "R1 cnt");
    bus_rd(2'd2, 16'h0000, "R1 cor");
    chk_irq(1'b0, "R1 irq");

    // R2 reserved bits
    bus_wr(2'd0, 16'hFF07);
    bus_rd(2'd0, 16'h0000, "R2 reserved");

    // R3 register map
    bus_wr(2'd2, 16'hFF5A);
    bus_rd(2'd2, 16'h005A, "R3 cor");
    bus_wr(2'd1, 16'h1203);
    bus_rd(2'd1, 16'h0003, "R3 cnt");

    // R5 stopped counter holds
    idle(40);
    bus_rd(2'd1, 16'h0003, "R5 hold");

    // R4 divide ratios: exact delta over 2*ratio cycles
    bus_wr(2'd2, 16'd200);
    for (int c = 1; c <= 7; c++) begin
      bus_wr(2'd0, 16'(c << 3));
      bus_wr(2'd1, 16'd0);
      bus_cap(2'd1, a);
      idle(2 * ratio[c] - 1);
      bus_cap(2'd1, b);
      check($sformatf("R4 code%0d delta", c), b - a, 16'd2);
    end

    // R11 write beats count step (divide by 2)
    bus_wr(2'd0, 16'h0008);
    bus_wr(2'd1, 16'd100);
    bus_rd(2'd1, 16'd100, "R11 write wins a");
    bus_wr(2'd1, 16'd150);
    bus_rd(2'd1, 16'd150, "R11 write wins b");

    // R6 wrap at constant 3: period 4 steps = 8 cycles
    bus_wr(2'd2, 16'd3);
    bus_wr(2'd1, 16'd0);
    idle(5);
    bus_cap(2'd1, a);
    idle(7);
    bus_cap(2'd1, b);
    check("R6 period", b, a);
    check("R6 bound", {15'd0, (a <= 16'd3)}, 16'd1);

    // R7 flag set by match; stop and move counter away
    bus_wr(2'd0, 16'h0000);
    bus_wr(2'd1, 16'd0);
    bus_wr(2'd2, 16'd5);
    // R8 write 0 without a prior read leaves flag
    bus_wr(2'd0, 16'h0000);
    bus_rd(2'd0, 16'h0080, "R8 no clear without read");
    bus_wr(2'd0, 16'h0000);
    bus_rd(2'd0, 16'h0000, "R8 clear after read");
    // R7 writing 1 does not set
    bus_wr(2'd0, 16'h0080);
    bus_rd(2'd0, 16'h0000, "R7 write one ignored");
    // R7 set again via match, R8 read saw 0 so write 0 does nothing
    bus_wr(2'd1, 16'd5);
    bus_wr(2'd0, 16'h0008);
    idle(1);
    bus_wr(2'd0, 16'h0000);
    bus_wr(2'd1, 16'd0);
    bus_wr(2'd0, 16'h0000);
    bus_rd(2'd0, 16'h0080, "R7 set by match / R8 unarmed write");
    bus_rd(2'd0, 16'h0080, "R8 arm");
    bus_wr(2'd0, 16'h0000);
    bus_rd(2'd0, 16'h0000, "R8 cleared");

    // R9: align to a slow step, then hold a match during a clearing write
    bus_wr(2'd2, 16'd200);
    bus_wr(2'd1, 16'd0);
    bus_wr(2'd0, 16'h0038);
    a = 16'd0;
    for (int i = 0; i < 5000 && a == 16'd0; i++) bus_cap(2'd1, a);
    check("R9 align", a, 16'd1);
    bus_wr(2'd2, 16'd9);
    bus_wr(2'd1, 16'd9);
    idle(1);
    bus_rd(2'd0, 16'h00B8, "R9 flag set");
    bus_wr(2'd0, 16'h0038);
    bus_rd(2'd0, 16'h00B8, "R9 set beats clear");

    // R10 interrupt follows flag and enable
    bus_wr(2'd0, 16'h0078);
    chk_irq(1'b1, "R10 irq on");
    bus_wr(2'd0, 16'h0038);
    chk_irq(1'b0, "R10 irq masked");
    bus_wr(2'd0, 16'h0040);
    bus_wr(2'd1, 16'd0);
    chk_irq(1'b1, "R10 irq stopped counter");
    bus_rd(2'd0, 16'h00C0, "R10 csr");
    bus_wr(2'd0, 16'h0040);
    chk_irq(1'b0, "R10 irq after clear");

    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule